// File: doc/BRIEF.md
# Relocation and Limit Address Translator

This block sits between a processor's address generation and main memory and turns each logical address issued by a user process into a physical address. A physical address is formed by adding a relocation value to the logical address. Every access is first compared against a limit value. An access at or beyond the limit, or one whose sum runs past the top of the physical space, is refused: it raises a trap and nothing goes to memory. The response is registered and arrives one cycle after the request.

The relocation and limit values live in two registers that only privileged (kernel) software may change. Software changes them either one at a time through a configuration write port, or together through a restore port that the context-switch logic uses. Both values are always visible on save outputs, so the pair can be stored with the outgoing process. The block keeps the current privilege mode. A mode-set port changes the mode, and any trap drops the mode back to kernel. When the processor is in kernel mode it may request bypass, and the logical address is then passed through unchanged with no limit check.

Top module: `reloc_guard`

## Requirements
- R1: After reset the relocation value is 0, the limit is 0, the mode is kernel (`mode_user` = 0), and `pa_vld`, `trap` and `priv_viol` are 0.
- R2: In user mode, a request whose logical address is below the limit and whose sum does not overflow gives `pa_vld` = 1 with `pa_addr` = relocation + logical address in the cycle after the request.
- R3: A translated request whose logical address (zero-extended) is greater than or equal to the limit gives `trap` = 1 and `pa_vld` = 0 in the cycle after the request.
- R4: A translated request for which relocation + logical address exceeds 2^PA_W − 1 gives `trap` = 1 and `pa_vld` = 0, even when the address is below the limit.
- R5: In kernel mode, `cfg_wr_en` writes `cfg_wdata` into the relocation register when `cfg_sel` = 0 and into the limit register when `cfg_sel` = 1. In user mode such a write leaves both registers unchanged, as seen on `ctx_base_o` and `ctx_limit_o`.
- R6: A configuration write or a restore attempted in user mode sets `priv_viol` to 1 in the following cycle only. Otherwise `priv_viol` is 0.
- R7: `ctx_base_o` and `ctx_limit_o` always show the current register values. In kernel mode `ctx_load_en` loads both registers from `ctx_base_i` and `ctx_limit_i` in one cycle, and it takes priority over a configuration write in the same cycle.
- R8: In kernel mode with `bypass_en` = 1, a request gives `pa_vld` = 1 with `pa_addr` equal to the zero-extended logical address, with no limit or overflow check. In user mode `bypass_en` has no effect.
- R9: In kernel mode without bypass, requests are translated and checked exactly as in user mode.
- R10: `pa_vld` and `trap` are never 1 together, neither is 1 without a request in the cycle before, and `pa_addr` is 0 whenever `pa_vld` is 0.
- R11: `mode_set_en` sets the mode to user when `mode_set_user` = 1 and to kernel when it is 0. A request that traps sets the mode to kernel, overriding a mode-set in the same cycle.
- R12: A request is translated with the register values and mode held before the edge. Writes, restores and mode changes in the same cycle affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Memory access request strobe |
| req_laddr | input | LA_W | Logical address of the request |
| bypass_en | input | 1 | Pass address through unchanged (kernel mode only) |
| pa_vld | output | 1 | Physical address valid |
| pa_addr | output | PA_W | Physical address, zero when not valid |
| trap | output | 1 | Protection trap for the previous request |
| mode_set_en | input | 1 | Load the privilege mode |
| mode_set_user | input | 1 | New mode: 1 user, 0 kernel |
| mode_user | output | 1 | Current mode: 1 user, 0 kernel |
| cfg_wr_en | input | 1 | Single-register write strobe |
| cfg_sel | input | 1 | Write target: 0 relocation, 1 limit |
| cfg_wdata | input | PA_W | Write data |
| ctx_load_en | input | 1 | Restore both registers |
| ctx_base_i | input | PA_W | Relocation value to restore |
| ctx_limit_i | input | PA_W | Limit value to restore |
| ctx_base_o | output | PA_W | Current relocation value for saving |
| ctx_limit_o | output | PA_W | Current limit value for saving |
| priv_viol | output | 1 | One-cycle flag for a refused user-mode write |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge once reset is released. They also assume that the logical width does not exceed the physical width, so that zero-extending a logical address keeps its value. The bench changes inputs only on falling edges and drives every input on every cycle, with no gaps. Its random mix biases relocation values toward the top of the physical space and logical addresses toward the limit, so the overflow and limit edges are reached often. Mode changes, refused writes and traps keep the mode switching between user and kernel, so the privilege-dependent checks see both modes.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  // Privilege mode held by the translator.
  typedef enum logic {
    PRIV_KERNEL = 1'b0,
    PRIV_USER   = 1'b1
  } priv_e;

  // Target of a single-register configuration write.
  typedef enum logic {
    SEL_RELOC = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_set_en,
  input  logic            mode_set_user,
  input  logic            trap_evt,
  input  logic            cfg_wr_en,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            ctx_load_en,
  input  logic [PA_W-1:0] ctx_base_i,
  input  logic [PA_W-1:0] ctx_limit_i,
  output logic [PA_W-1:0] reloc_q,
  output logic [PA_W-1:0] limit_q,
  output priv_e           priv_q,
  output logic            viol_q
);

  logic     is_kernel;
  logic     wr_attempt;
  logic     wr_denied;
  logic     cfg_take;
  logic     ctx_take;
  cfg_sel_e sel;

  assign is_kernel  = (priv_q == PRIV_KERNEL);
  assign wr_attempt = cfg_wr_en | ctx_load_en;
  assign wr_denied  = wr_attempt & ~is_kernel;
  assign ctx_take   = ctx_load_en & is_kernel;
  assign cfg_take   = cfg_wr_en & is_kernel & ~ctx_load_en;
  assign sel        = cfg_sel_e'(cfg_sel);

  // Relocation and limit registers; a restore wins over a single write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reloc_q <= '0;
      limit_q <= '0;
    end else if (ctx_take) begin
      reloc_q <= ctx_base_i;
      limit_q <= ctx_limit_i;
    end else if (cfg_take) begin
      if (sel == SEL_RELOC) reloc_q <= cfg_wdata;
      else                  limit_q <= cfg_wdata;
    end
  end

  // Mode register; a trap returns control to kernel mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRIV_KERNEL;
    end else if (trap_evt) begin
      priv_q <= PRIV_KERNEL;
    end else if (mode_set_en) begin
      priv_q <= mode_set_user ? PRIV_USER : PRIV_KERNEL;
    end
  end

  // Refused-write flag, one cycle per refused attempt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= wr_denied;
  end

  // R5: a user-mode attempt leaves both registers untouched.
  assert_user_wr_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attempt && priv_q == PRIV_USER) |=> ($stable(reloc_q) && $stable(limit_q)));

  // R6: the flag follows a refused attempt, and only such an attempt.
  assert_viol_after_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attempt && priv_q == PRIV_USER) |=> viol_q);
  assert_viol_needs_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_attempt || priv_q == PRIV_KERNEL) |=> !viol_q);

  // R7: a kernel restore loads the pair together.
  assert_restore_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load_en && priv_q == PRIV_KERNEL) |=>
      (reloc_q == $past(ctx_base_i) && limit_q == $past(ctx_limit_i)));

  // R11: a trap leaves the processor in kernel mode.
  assert_trap_to_kernel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> (priv_q == PRIV_KERNEL));

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [LA_W-1:0] req_laddr,
  input  logic            bypass_en,
  input  logic [PA_W-1:0] reloc,
  input  logic [PA_W-1:0] limit,
  input  priv_e           priv,
  output logic            trap_evt,
  output logic            pa_vld_q,
  output logic            trap_q,
  output logic [PA_W-1:0] pa_q
);

  localparam int SUM_W = PA_W + 1;

  // Relocated address with one carry bit above the physical space.
  function automatic logic [SUM_W-1:0] relocate(input logic [PA_W-1:0] b,
                                                input logic [LA_W-1:0] la);
    return {1'b0, b} + SUM_W'(la);
  endfunction

  // Legal when strictly below the limit.
  function automatic logic below_limit(input logic [LA_W-1:0] la,
                                       input logic [PA_W-1:0] lim);
    return PA_W'(la) < lim;
  endfunction

  logic             do_bypass;
  logic [SUM_W-1:0] sum;
  logic             sum_ovf;
  logic             out_of_range;
  logic             fault;
  logic             pass_evt;
  logic [PA_W-1:0]  pa_next;

  assign do_bypass    = bypass_en & (priv == PRIV_KERNEL);
  assign sum          = relocate(reloc, req_laddr);
  assign sum_ovf      = sum[PA_W];
  assign out_of_range = ~below_limit(req_laddr, limit);
  assign fault        = ~do_bypass & (out_of_range | sum_ovf);
  assign trap_evt     = req_vld & fault;
  assign pass_evt     = req_vld & ~fault;
  assign pa_next      = do_bypass ? PA_W'(req_laddr) : sum[PA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_vld_q <= 1'b0;
      trap_q   <= 1'b0;
      pa_q     <= '0;
    end else begin
      pa_vld_q <= pass_evt;
      trap_q   <= trap_evt;
      pa_q     <= pass_evt ? pa_next : '0;
    end
  end

  // R10: never both responses, none without a request, quiet address.
  assert_resp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_vld_q && trap_q));
  assert_resp_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_vld_q || trap_q) |-> $past(req_vld));
  assert_addr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_vld_q |-> (pa_q == '0));

  // R3: at or past the limit traps unless bypassed.
  assert_limit_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !(bypass_en && priv == PRIV_KERNEL) && PA_W'(req_laddr) >= limit)
      |=> trap_q);

  // R4: headroom above the relocation value smaller than the address traps.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !(bypass_en && priv == PRIV_KERNEL) &&
     reloc > ({PA_W{1'b1}} - PA_W'(req_laddr))) |=> trap_q);

  // R8: kernel bypass hands the logical address straight through.
  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && bypass_en && priv == PRIV_KERNEL) |=>
      (pa_vld_q && pa_q == PA_W'($past(req_laddr))));

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic [LA_W-1:0] req_laddr,
  input  logic            bypass_en,
  output logic            pa_vld,
  output logic [PA_W-1:0] pa_addr,
  output logic            trap,
  input  logic            mode_set_en,
  input  logic            mode_set_user,
  output logic            mode_user,
  input  logic            cfg_wr_en,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            ctx_load_en,
  input  logic [PA_W-1:0] ctx_base_i,
  input  logic [PA_W-1:0] ctx_limit_i,
  output logic [PA_W-1:0] ctx_base_o,
  output logic [PA_W-1:0] ctx_limit_o,
  output logic            priv_viol
);

  logic [PA_W-1:0] reloc_w;
  logic [PA_W-1:0] limit_w;
  priv_e           priv_w;
  logic            trap_evt_w;

  reloc_regs #(.PA_W(PA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_set_en  (mode_set_en),
    .mode_set_user(mode_set_user),
    .trap_evt     (trap_evt_w),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .ctx_load_en  (ctx_load_en),
    .ctx_base_i   (ctx_base_i),
    .ctx_limit_i  (ctx_limit_i),
    .reloc_q      (reloc_w),
    .limit_q      (limit_w),
    .priv_q       (priv_w),
    .viol_q       (priv_viol)
  );

  reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_laddr(req_laddr),
    .bypass_en(bypass_en),
    .reloc    (reloc_w),
    .limit    (limit_w),
    .priv     (priv_w),
    .trap_evt (trap_evt_w),
    .pa_vld_q (pa_vld),
    .trap_q   (trap),
    .pa_q     (pa_addr)
  );

  assign mode_user   = (priv_w == PRIV_USER);
  assign ctx_base_o  = reloc_w;
  assign ctx_limit_o = limit_w;

  // R2: a user request inside the window returns the relocated address.
  assert_user_xlate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && priv_w == PRIV_USER && !trap_evt_w) |=>
      (pa_vld && pa_addr == $past(reloc_w) + PA_W'($past(req_laddr))));

  // R11: a mode set without a trap takes effect at the next edge.
  assert_mode_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set_en && !trap_evt_w) |=> (mode_user == $past(mode_set_user)));

endmodule

// File: tb/reloc_guard_bench.sv
module reloc_guard_bench;

  localparam int LA_W     = 16;
  localparam int PA_W     = 20;
  localparam int CLK_PER  = 10;
  localparam int N_RANDOM = 4000;
  localparam longint PA_MAX = (64'd1 << PA_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_vld = 1'b0;
  logic [LA_W-1:0] req_laddr = '0;
  logic            bypass_en = 1'b0;
  logic            pa_vld;
  logic [PA_W-1:0] pa_addr;
  logic            trap;
  logic            mode_set_en = 1'b0;
  logic            mode_set_user = 1'b0;
  logic            mode_user;
  logic            cfg_wr_en = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic            ctx_load_en = 1'b0;
  logic [PA_W-1:0] ctx_base_i = '0;
  logic [PA_W-1:0] ctx_limit_i = '0;
  logic [PA_W-1:0] ctx_base_o;
  logic [PA_W-1:0] ctx_limit_o;
  logic            priv_viol;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Bench copy of the architectural state.
  longint m_reloc = 0;
  longint m_limit = 0;
  bit     m_user  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  reloc_guard #(.LA_W(LA_W), .PA_W(PA_W)) u_reloc_guard (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_laddr(req_laddr),
    .bypass_en(bypass_en), .pa_vld(pa_vld), .pa_addr(pa_addr), .trap(trap),
    .mode_set_en(mode_set_en), .mode_set_user(mode_set_user), .mode_user(mode_user),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctx_load_en(ctx_load_en), .ctx_base_i(ctx_base_i), .ctx_limit_i(ctx_limit_i),
    .ctx_base_o(ctx_base_o), .ctx_limit_o(ctx_limit_o), .priv_viol(priv_viol)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  // Expected sum of relocation and address, checked against the top of space.
  function automatic bit exp_ovf(input longint b, input longint la);
    return (b + la) > PA_MAX;
  endfunction

  function automatic bit exp_fault(input longint b, input longint lim, input longint la,
                                   input bit user, input bit byp);
    if (!user && byp) return 1'b0;
    return (la >= lim) || exp_ovf(b, la);
  endfunction

  // One cycle: drive at a falling edge, check at the next falling edge.
  task automatic cycle(input bit rq, input longint la, input bit byp,
                       input bit ms, input bit msu,
                       input bit cw, input bit cs, input longint cd,
                       input bit cl, input longint cb, input longint clim);
    bit     e_pa_vld, e_trap, e_viol, fault, kern_byp;
    longint e_pa;
    string  xtag, rtag;
    req_vld = rq; req_laddr = LA_W'(la); bypass_en = byp;
    mode_set_en = ms; mode_set_user = msu;
    cfg_wr_en = cw; cfg_sel = cs; cfg_wdata = PA_W'(cd);
    ctx_load_en = cl; ctx_base_i = PA_W'(cb); ctx_limit_i = PA_W'(clim);

    kern_byp = !m_user && byp;
    fault    = exp_fault(m_reloc, m_limit, la, m_user, byp);
    e_trap   = rq && fault;
    e_pa_vld = rq && !fault;
    e_pa     = !e_pa_vld ? 0 : (kern_byp ? la : m_reloc + la);
    e_viol   = m_user && (cw || cl);
    if (!rq)                       xtag = "R10";
    else if (kern_byp)             xtag = "R8";
    else if (exp_ovf(m_reloc, la)) xtag = "R4";
    else if (la >= m_limit)        xtag = "R3";
    else if (m_user)               xtag = "R2";
    else                           xtag = "R9";
    rtag = cl ? "R7" : "R5";

    if (!m_user) begin
      if (cl) begin m_reloc = cb; m_limit = clim; end
      else if (cw) begin
        if (cs) m_limit = cd; else m_reloc = cd;
      end
    end
    if (e_trap) m_user = 1'b0;
    else if (ms) m_user = msu;

    @(posedge clk);
    @(negedge clk);
    chk(pa_vld == e_pa_vld, xtag, pa_vld, e_pa_vld);
    chk(trap == e_trap, xtag, trap, e_trap);
    chk(pa_addr == PA_W'(e_pa), xtag, pa_addr, e_pa);
    chk(priv_viol == e_viol, "R6", priv_viol, e_viol);
    chk(mode_user == m_user, "R11", mode_user, m_user);
    chk(ctx_base_o == PA_W'(m_reloc), rtag, ctx_base_o, m_reloc);
    chk(ctx_limit_o == PA_W'(m_limit), rtag, ctx_limit_o, m_limit);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic req(input longint la, input bit byp);
    cycle(1, la, byp, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic set_mode(input bit u);
    cycle(0, 0, 0, 1, u, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input bit sel, input longint d);
    cycle(0, 0, 0, 0, 0, 1, sel, d, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, N_RANDOM);
    finish_run();
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state.
    chk(mode_user == 1'b0, "R1", mode_user, 0);
    chk(ctx_base_o == '0, "R1", ctx_base_o, 0);
    chk(ctx_limit_o == '0, "R1", ctx_limit_o, 0);
    chk(!pa_vld && !trap && !priv_viol, "R1", {pa_vld, trap, priv_viol}, 0);

    // Limit zero: any user access traps; trap returns to kernel.
    set_mode(1);
    req(0, 0);
    // Kernel writes, then the limit edge.
    wr(0, 'h1000);
    wr(1, 'h0100);
    set_mode(1);
    req('h00FF, 0);
    set_mode(1);
    req('h0100, 0);
    // User write attempts are refused and flagged.
    set_mode(1);
    wr(0, 'h7777);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 'h1, 'h2);
    idle();
    // Overflow past the top of the physical space.
    set_mode(0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, PA_MAX - 'h10, 'hFFFFF);
    set_mode(1);
    req('h0F, 0);
    set_mode(1);
    req('h11, 0);
    // Bypass in kernel, then ignored in user.
    req('hFFFF, 1);
    set_mode(1);
    req('h05, 1);
    // R12: same-cycle write and request use the old relocation value.
    set_mode(0);
    wr(0, 'h200);
    wr(1, 'h8000);
    cycle(1, 'h10, 0, 0, 0, 1, 0, 'h300, 0, 0, 0);
    chk(pa_addr == PA_W'('h210), "R12", pa_addr, 'h210);
    req('h10, 0);
    chk(pa_addr == PA_W'('h310), "R12", pa_addr, 'h310);
    // Restore beats single write in the same cycle.
    cycle(0, 0, 0, 0, 0, 1, 0, 'h444, 1, 'h555, 'h666);
    // Trap overrides a mode set in the same cycle.
    set_mode(1);
    cycle(1, 'h7000, 0, 1, 1, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < N_RANDOM; i++) begin
      bit     rq, byp, ms, msu, cw, cs, cl;
      longint la, cd, cb, clim;
      rq  = ($urandom % 10) < 6;
      byp = ($urandom % 10) < 3;
      ms  = ($urandom % 10) < 2;
      msu = ($urandom % 10) < 7;
      cw  = ($urandom % 10) < 2;
      cs  = $urandom % 2;
      cl  = ($urandom % 20) == 0;
      if (m_limit > 0 && ($urandom % 2) == 1) la = $urandom % (m_limit + 2);
      else la = $urandom;
      la = la & ((64'd1 << LA_W) - 1);
      cd = (($urandom % 4) == 0) ? PA_MAX - ($urandom % 'h20000) : ($urandom & PA_MAX);
      if (cs) cd = $urandom % 'h20000;
      cb = (($urandom % 4) == 0) ? PA_MAX - ($urandom % 'h20000) : ($urandom & PA_MAX);
      clim = $urandom % 'h20000;
      cycle(rq, la, byp, ms, msu, cw, cs, cd, cl, cb, clim);
    end
    finish_run();
  end

endmodule